// File: doc/BRIEF.md
# Watchdog Timer with Divide-by-Eight Service Stage

This block is a computer-operating-properly watchdog. A timer elsewhere on the chip supplies a periodic one-cycle tick. The watchdog counts those ticks in a 3-bit divide-by-eight stage. If eight ticks arrive with no service in between, it raises a single-cycle internal reset request.

Software services the watchdog with one bus write to a dedicated clear address. A service write zeroes only the 3-bit stage. The divider that produces the tick keeps running, so the tick phase is not reset. As a result, the real timeout after a service falls between seven and eight tick periods. A static strap input turns the whole function on or off.

The block has an asynchronous active-low reset. Reset is asserted at once and released in step with the clock through a two-flop synchronizer. So the block takes effect from the second rising edge after `rst_n` goes high.

Top module: `cop_watchdog`

## Requirements
- R1: While reset is active, and with no ticks after it is released, `cop_rst_o` stays 0 and the tick count is 0.
- R2: With the strap high and no service, the eighth tick sampled since the count was last zeroed makes `cop_rst_o` go to 1 in the cycle after the edge that sampled that tick. Fewer ticks never do this.
- R3: The reset request lasts exactly one clock cycle. The count returns to 0, so a further timeout needs eight more ticks.
- R4: A write with `bus_we_i`=1, `bus_addr_i`=0x0FF0 and `bus_wdata_i` bit 0 = 0 sets the count to 0. Eight new ticks are then needed before a reset request.
- R5: A write to 0x0FF0 with `bus_wdata_i` bit 0 = 1 leaves the count unchanged.
- R6: A write to any other address, or bus activity with `bus_we_i`=0, leaves the count unchanged.
- R7: When a service write and a tick are sampled at the same edge, the service wins. The count becomes 0 and no reset request is issued.
- R8: While `cop_en_i`=0, the count is held at 0 and `cop_rst_o` stays 0. After the strap is raised again, eight ticks are needed for a timeout.
- R9: Ticks on back-to-back cycles each count once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle periodic tick from the timer divider |
| bus_addr_i | input | 16 | Write address |
| bus_wdata_i | input | 8 | Write data; bit 0 selects service (0) or no-op (1) |
| bus_we_i | input | 1 | Write strobe |
| cop_en_i | input | 1 | Static enable strap |
| cop_rst_o | output | 1 | One-cycle internal reset request |

## Verification
The hardest case to reach is the seven-versus-eight-period spread. It requires a service write to land at every possible phase of the tick stream, including the very cycle a tick arrives and the very cycle the count would wrap. The stimulus sends ticks at random gaps, sometimes on back-to-back cycles. It drops service writes in at random points, in part on the same cycle as a tick. It also mixes in near-miss writes (wrong address, data bit 0 set, strobe low) and strap toggles. A bench model follows the count and predicts every cycle of `cop_rst_o`.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int unsigned COP_ADDR_W   = 16;
  localparam int unsigned COP_DATA_W   = 8;
  localparam int unsigned COP_DIV_BITS = 3;
  localparam logic [COP_ADDR_W-1:0] COP_CLR_ADDR = 16'h0FF0;
  localparam int unsigned COP_CLR_BIT  = 0;
  localparam int unsigned COP_SYNC_STAGES = 2;
endpackage

// File: rtl/cop_rst_sync.sv
module cop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cop_clr_decode.sv
module cop_clr_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '0,
  parameter int unsigned CLR_BIT  = 0
) (
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              clr_o
);
  logic addr_hit;
  logic data_clr;
  logic unused_wdata;

  always_comb begin
    addr_hit = (bus_addr_i == CLR_ADDR);
    data_clr = ~bus_wdata_i[CLR_BIT];
    clr_o    = bus_we_i & addr_hit & data_clr;
  end

  // Only the selected data bit matters; the others are read for width only.
  assign unused_wdata = ^bus_wdata_i;
endmodule

// File: rtl/cop_div_stage.sv
module cop_div_stage #(
  parameter int unsigned DIV_BITS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic wrap_o
);
  localparam logic [DIV_BITS-1:0] TERM = '1;

  logic [DIV_BITS-1:0] cnt_q, cnt_d;
  logic                wrap_q, wrap_d;
  logic                cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (!en_i || clr_i) begin
      cnt_ce = 1'b1;
      cnt_d  = '0;
    end else if (tick_i) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q + 1'b1;
      wrap_d = (cnt_q == TERM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign wrap_o = wrap_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clr_i) |=> (cnt_q == '0 && !wrap_o)); // R7
  AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0 && !wrap_o)); // R8
  AST_WRAP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && tick_i && cnt_q == TERM) |=> (wrap_o && cnt_q == '0)); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && tick_i && cnt_q != TERM) |=>
      (!wrap_o && cnt_q == DIV_BITS'($past(cnt_q) + 1'b1))); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && !tick_i) |=> ($stable(cnt_q) && !wrap_o)); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o); // R3
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int unsigned ADDR_W   = COP_ADDR_W,
  parameter int unsigned DATA_W   = COP_DATA_W,
  parameter int unsigned DIV_BITS = COP_DIV_BITS,
  parameter logic [ADDR_W-1:0] CLR_ADDR = COP_CLR_ADDR,
  parameter int unsigned CLR_BIT  = COP_CLR_BIT,
  parameter int unsigned SYNC_STAGES = COP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  input  logic              cop_en_i,
  output logic              cop_rst_o
);
  logic rst_sync_n;
  logic clr;

  cop_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cop_clr_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLR_ADDR (CLR_ADDR),
    .CLR_BIT  (CLR_BIT)
  ) u_dec (
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .clr_o       (clr)
  );

  cop_div_stage #(.DIV_BITS(DIV_BITS)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (cop_en_i),
    .clr_i  (clr),
    .tick_i (tick_i),
    .wrap_o (cop_rst_o)
  );

  AST_NO_FALSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we_i && bus_wdata_i[CLR_BIT]) |-> !clr); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> !cop_rst_o); // R1
endmodule

// File: tb/cop_watchdog_test.sv
`timescale 1ns/1ps
module cop_watchdog_test;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        we;
  logic        en;
  logic        cop_rst;

  int n_checks;
  int n_fails;
  int cycles;
  bit done;

  logic [2:0] m_cnt;
  logic       m_rst;

  cop_watchdog uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_we_i   (we),
    .cop_en_i   (en),
    .cop_rst_o  (cop_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [3:0] model_next(input logic [2:0] c, input logic t,
      input logic w, input logic [15:0] a, input logic [7:0] d, input logic e);
    logic svc;
    svc = w && (a == 16'h0FF0) && !d[0];
    if (!e || svc) return 4'b0000;
    if (t) return {(c == 3'd7), 3'(c + 3'd1)};
    return {1'b0, c};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: cop_rst_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req, input logic t, input logic w,
      input logic [15:0] a, input logic [7:0] d, input logic e);
    logic [3:0] nx;
    tick = t; we = w; addr = a; wdata = d; en = e;
    @(posedge clk);
    nx = model_next(m_cnt, t, w, a, d, e);
    m_cnt = nx[2:0];
    m_rst = nx[3];
    @(negedge clk);
    check(req, cop_rst, m_rst);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) step(req, 1'b0, 1'b0, 16'h0, 8'h0, 1'b1);
  endtask

  task automatic service(input string req);
    step(req, 1'b0, 1'b1, 16'h0FF0, 8'hFE, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; cycles = 0; done = 1'b0;
    m_cnt = 3'd0; m_rst = 1'b0;
    tick = 0; we = 0; addr = 0; wdata = 0; en = 1; rst_n = 0;
    void'($urandom(32'd7391));
    // R1: output quiet while reset is held
    repeat (3) @(negedge clk);
    check("R1", cop_rst, 1'b0);
    rst_n = 1'b1;
    idle("R1", 4);

    // R2: seven ticks then the eighth fires, with gaps between ticks
    service("R4");
    for (int i = 0; i < 7; i++) begin
      step("R2", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
      idle("R2", 2);
    end
    step("R2", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R2", cop_rst, 1'b1);
    // R3: single-cycle pulse, count restarted
    idle("R3", 1);
    check("R3", cop_rst, 1'b0);
    for (int i = 0; i < 8; i++) step("R9", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R9", cop_rst, 1'b1);

    // R4: service mid-count restarts eight-tick window
    for (int i = 0; i < 5; i++) step("R4", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    service("R4");
    for (int i = 0; i < 7; i++) step("R4", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R4", cop_rst, 1'b0);
    // R5: data bit 0 set does not service
    step("R5", 1'b0, 1'b1, 16'h0FF0, 8'h01, 1'b1);
    step("R5", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R5", cop_rst, 1'b1);

    // R6: wrong address and strobe low do not service
    for (int i = 0; i < 7; i++) step("R6", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    step("R6", 1'b0, 1'b1, 16'h0FF1, 8'h00, 1'b1);
    step("R6", 1'b0, 1'b0, 16'h0FF0, 8'h00, 1'b1);
    step("R6", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R6", cop_rst, 1'b1);

    // R7: service with tick on the would-be wrap cycle
    for (int i = 0; i < 7; i++) step("R7", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    step("R7", 1'b1, 1'b1, 16'h0FF0, 8'h00, 1'b1);
    check("R7", cop_rst, 1'b0);
    for (int i = 0; i < 7; i++) step("R7", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R7", cop_rst, 1'b0);
    service("R7");

    // R8: disabled strap holds count at zero
    for (int i = 0; i < 5; i++) step("R8", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    for (int i = 0; i < 20; i++) step("R8", 1'b1, 1'b0, 16'h0, 8'h0, 1'b0);
    for (int i = 0; i < 7; i++) step("R8", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R8", cop_rst, 1'b0);
    step("R8", 1'b1, 1'b0, 16'h0, 8'h0, 1'b1);
    check("R8", cop_rst, 1'b1);

    // Random mix, all requirements checked by the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic t, w, e;
      logic [15:0] a;
      logic [7:0] d;
      r = $urandom_range(99);
      t = ($urandom_range(3) == 0);
      w = (r < 6);
      a = ($urandom_range(3) == 0) ? 16'($urandom) : 16'h0FF0;
      d = 8'($urandom);
      e = ($urandom_range(49) != 0);
      step(w ? "R4" : (t ? "R2" : "R6"), t, w, a, d, e);
    end

    finish_run();
  end
endmodule